// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs the serial management link between a MAC-side controller and an Ethernet PHY. A host pulses `start_i` with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block then produces one complete management frame on a clock wire (`mdc_o`) and a shared data wire (`mdio_o`, `mdio_oe_o`, `mdio_i`). When the frame is over it pulses `done_o` for one cycle. After a read it presents the register value on `rd_data_o`. If the PHY did not answer the turnaround of a read, it raises `err_o` instead.

Each frame is a sequence of bit slots. A slot is a low phase followed by a high phase on `mdc_o`, and each phase lasts `half_div_i` clocks. A value of 0 is treated as 1. At a 250 MHz system clock, a value of 250 gives a 1 µs half-period. `half_div_i` is latched when a frame is accepted.

The controller is a state machine with these states:
- IDLE: waiting for a request.
- PRE: the preamble.
- HDR: start bits, opcode and the two addresses.
- TA: turnaround.
- DATA: the 16 data bits.
- TAIL: the closing slot.
- FLUSH: recovery clocks after a failed read.

Its transitions are:
- IDLE→PRE on an accepted start.
- PRE→HDR after 32 slots.
- HDR→TA after 14 slots.
- TA→DATA after 2 slots on a write, or after 1 slot on a read whose turnaround sample was 0.
- TA→FLUSH on a read whose turnaround sample was 1.
- DATA→TAIL after 16 slots.
- TAIL→IDLE after 1 slot.
- FLUSH→IDLE after 32 slots.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc_o`=1, `mdio_oe_o`=0, `done_o`=0, `err_o`=0 and `rd_data_o`=0.
- R2: Every frame opens with 32 slots in which `mdio_oe_o`=1 and `mdio_o`=1. Slots are counted at `mdc_o` rising edges, starting at index 0.
- R3: Slots 32 and 33 carry the start pattern 0 then 1. Slots 34 and 35 carry the opcode: 1,0 for a read (`rd_nwr_i`=1) or 0,1 for a write.
- R4: Slots 36..40 carry the PHY address and slots 41..45 carry the register address. Both go out most significant bit first with the output enabled.
- R5: `mdio_o` and `mdio_oe_o` change only while `mdc_o` is low. Each `mdc_o` level lasts exactly `half_div_i` clocks, with 0 acting as 1.
- R6: On a read, `mdio_oe_o` is 0 from slot 46 to the end of the frame, and the line is sampled at the last clock of each high phase. The slot-46 sample must be 0. Slots 47..62 supply the data MSB first, slot 63 is one closing slot, and the frame has 64 slots. At the end, `rd_data_o` holds the data and `err_o`=0.
- R7: On a read whose slot-46 sample is 1, the block gives 32 more slots with the output released, making 79 slots in all. It then ends with `err_o`=1 and `rd_data_o`=0.
- R8: On a write, slots 46 and 47 drive 1 then 0, and slots 48..63 drive the data MSB first. Slot 64 has the output released, and the frame has 65 slots.
- R9: `done_o` is a single-cycle pulse at the end of each frame. `mdc_o` is 1 while it is high and stays 1 while idle.
- R10: `start_i` is ignored while a frame is in progress. The running frame keeps its bits and slot count and produces one `done_o`.
- R11: `rd_data_o` and `err_o` hold their values after `done_o` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken only in IDLE |
| rd_nwr_i | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wr_data_i | input | 16 | Value for a write frame |
| half_div_i | input | DIV_W (8) | Clocks per MDC half-period (0 acts as 1) |
| rd_data_o | output | 16 | Value read from the PHY |
| done_o | output | 1 | End-of-frame pulse |
| err_o | output | 1 | Read turnaround not pulled low |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Output enable for the data wire |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest cases to reach from the ports are a PHY that leaves the turnaround high, and a request that arrives in the middle of a frame. Both depend on what the far end does at one exact slot. The bench therefore contains a PHY model that counts `mdc_o` rising edges and drives `mdio_i` on each falling edge, according to the index of the slot about to start. This lets it force slot 46 high to enter FLUSH, or feed chosen data patterns into slots 47..62. A second request is injected a fixed number of clocks into a write frame, and the bench then compares the whole captured slot sequence and the number of completion pulses.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA,
        ST_TAIL,
        ST_FLUSH
    } mdio_state_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] lim_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim_eff;

    assign lim_eff = (lim_i == '0) ? DIV_W'(1) : lim_i;
    assign tick_o  = run_i && (cnt_q == lim_eff - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (clr_i || !run_i || tick_o) cnt_q <= '0;
        else                                cnt_q <= cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data_o <= '0;
        else if (clr_i)   data_o <= '0;
        else if (shift_i) data_o <= {data_o[W-2:0], bit_i};
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int DIV_W     = 8,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int PRE_LEN   = 32,
    parameter int FLUSH_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_nwr_i,
    input  logic [ADDR_W-1:0] phy_addr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [DIV_W-1:0]  half_div_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              done_o,
    output logic              err_o,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i
);
    import mdio_pkg::*;

    localparam int HDR_W   = 4 + 2 * ADDR_W;
    localparam int MAX_LEN = int'(max_of(max_of(PRE_LEN, FLUSH_LEN), max_of(DATA_W, HDR_W)));
    localparam int CNT_W   = $clog2(MAX_LEN);

    mdio_state_e       state_q, state_d;
    logic [CNT_W-1:0]  idx_q, idx_d;
    logic              hi_q, hi_d;
    logic              mdc_q, mdc_d;
    logic              mdo_q, mdo_d;
    logic              oe_q, oe_d;
    logic              done_q, done_d;
    logic              err_q, err_d;
    logic              rd_q, rd_d;
    logic [HDR_W-1:0]  hdr_q, hdr_d;
    logic [DATA_W-1:0] wd_q, wd_d;
    logic [DIV_W-1:0]  div_q, div_d;
    logic              accept, shift_en, tick;

    mdio_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .run_i  (state_q != ST_IDLE),
        .lim_i  (div_q),
        .tick_o (tick)
    );

    mdio_rx_shift #(.W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept),
        .shift_i (shift_en),
        .bit_i   (mdio_i),
        .data_o  (rd_data_o)
    );

    // next-state and slot logic
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        hi_d     = hi_q;
        mdc_d    = mdc_q;
        mdo_d    = mdo_q;
        oe_d     = oe_q;
        done_d   = 1'b0;
        err_d    = err_q;
        rd_d     = rd_q;
        hdr_d    = hdr_q;
        wd_d     = wd_q;
        div_d    = div_q;
        accept   = 1'b0;
        shift_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept  = 1'b1;
                    state_d = ST_PRE;
                    idx_d   = '0;
                    hi_d    = 1'b0;
                    mdc_d   = 1'b0;
                    mdo_d   = 1'b1;
                    oe_d    = 1'b1;
                    err_d   = 1'b0;
                    rd_d    = rd_nwr_i;
                    hdr_d   = {2'b01, (rd_nwr_i ? 2'b10 : 2'b01), phy_addr_i, reg_addr_i};
                    wd_d    = wr_data_i;
                    div_d   = half_div_i;
                end
            end
            default: begin
                if (tick && !hi_q) begin
                    hi_d  = 1'b1;
                    mdc_d = 1'b1;
                end else if (tick) begin
                    hi_d  = 1'b0;
                    mdc_d = 1'b0;
                    idx_d = idx_q + CNT_W'(1);
                    unique case (state_q)
                        ST_PRE: begin
                            if (idx_q == CNT_W'(PRE_LEN - 1)) begin
                                state_d = ST_HDR;
                                idx_d   = '0;
                                mdo_d   = hdr_q[HDR_W-1];
                            end
                        end
                        ST_HDR: begin
                            hdr_d = hdr_q << 1;
                            mdo_d = hdr_q[HDR_W-2];
                            if (idx_q == CNT_W'(HDR_W - 1)) begin
                                state_d = ST_TA;
                                idx_d   = '0;
                                mdo_d   = 1'b1;
                                oe_d    = !rd_q;
                            end
                        end
                        ST_TA: begin
                            if (rd_q) begin
                                idx_d   = '0;
                                state_d = mdio_i ? ST_FLUSH : ST_DATA;
                            end else if (idx_q == '0) begin
                                mdo_d = 1'b0;
                            end else begin
                                state_d = ST_DATA;
                                idx_d   = '0;
                                mdo_d   = wd_q[DATA_W-1];
                            end
                        end
                        ST_DATA: begin
                            if (rd_q) begin
                                shift_en = 1'b1;
                            end else begin
                                wd_d  = wd_q << 1;
                                mdo_d = wd_q[DATA_W-2];
                            end
                            if (idx_q == CNT_W'(DATA_W - 1)) begin
                                state_d = ST_TAIL;
                                idx_d   = '0;
                                oe_d    = 1'b0;
                                mdo_d   = 1'b1;
                            end
                        end
                        ST_TAIL: begin
                            state_d = ST_IDLE;
                            idx_d   = '0;
                            mdc_d   = 1'b1;
                            done_d  = 1'b1;
                        end
                        ST_FLUSH: begin
                            if (idx_q == CNT_W'(FLUSH_LEN - 1)) begin
                                state_d = ST_IDLE;
                                idx_d   = '0;
                                mdc_d   = 1'b1;
                                done_d  = 1'b1;
                                err_d   = 1'b1;
                            end
                        end
                        default: begin
                            state_d = ST_IDLE;
                            mdc_d   = 1'b1;
                            oe_d    = 1'b0;
                        end
                    endcase
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            hi_q   <= 1'b0;
            mdc_q  <= 1'b1;
            mdo_q  <= 1'b1;
            oe_q   <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            rd_q   <= 1'b0;
            hdr_q  <= '0;
            wd_q   <= '0;
            div_q  <= '0;
        end else begin
            idx_q  <= idx_d;
            hi_q   <= hi_d;
            mdc_q  <= mdc_d;
            mdo_q  <= mdo_d;
            oe_q   <= oe_d;
            done_q <= done_d;
            err_q  <= err_d;
            rd_q   <= rd_d;
            hdr_q  <= hdr_d;
            wd_q   <= wd_d;
            div_q  <= div_d;
        end
    end

    assign mdc_o     = mdc_q;
    assign mdio_o    = mdo_q;
    assign mdio_oe_o = oe_q;
    assign done_o    = done_q;
    assign err_o     = err_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic done_i,
    input logic err_i,
    input logic mdc_i,
    input logic mdo_i,
    input logic oe_i,
    input logic busy_i,
    input logic pre_i
);
    assert_mdio_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_i && $past(mdc_i)) |-> ($stable(mdo_i) && $stable(oe_i)));

    assert_preamble_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i |-> (oe_i && mdo_i));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !done_i);

    assert_done_mdc_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> mdc_i);

    assert_idle_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> !oe_i);

    assert_err_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_i) |-> done_i);

    assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !$past(busy_i)) |-> $stable(err_i));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .done_i (done_o),
    .err_i  (err_o),
    .mdc_i  (mdc_o),
    .mdo_i  (mdio_o),
    .oe_i   (mdio_oe_o),
    .busy_i (state_q != mdio_pkg::ST_IDLE),
    .pre_i  (state_q == mdio_pkg::ST_PRE)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  half_div = 8'd2;
    logic [15:0] rd_data;
    logic        done, err, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int nchk = 0, nfail = 0;
    int rise_cnt = 0, done_cnt = 0, viol = 0;
    logic cap_v [0:127];
    logic cap_oe[0:127];
    logic        phy_rd = 1'b0;
    logic        phy_ta = 1'b0;
    logic [15:0] phy_dat = '0;
    logic prev_mdc = 1'b1, prev_o = 1'b1, prev_oe = 1'b0;

    always #2 clk = ~clk;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rd_nwr_i(rd_nwr),
        .phy_addr_i(phy_addr), .reg_addr_i(reg_addr), .wr_data_i(wr_data),
        .half_div_i(half_div), .rd_data_o(rd_data), .done_o(done), .err_o(err),
        .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: record each slot at MDC rise, drive the line at MDC fall
    always @(posedge mdc) begin
        if (rise_cnt < 128) begin
            cap_v[rise_cnt]  = mdio_o;
            cap_oe[rise_cnt] = mdio_oe;
        end
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge mdc) begin
        if (phy_rd && rise_cnt == 46)                   mdio_i = phy_ta;
        else if (phy_rd && rise_cnt >= 47 && rise_cnt <= 62) mdio_i = phy_dat[62 - rise_cnt];
        else                                             mdio_i = 1'b1;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt = done_cnt + 1;
            if (mdc && prev_mdc && (mdio_o != prev_o || mdio_oe != prev_oe)) viol = viol + 1;
        end
        prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic launch(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] wd, input logic [7:0] dv,
                          input logic ta, input logic [15:0] pd);
        @(negedge clk);
        rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; half_div = dv;
        phy_rd = rd; phy_ta = ta; phy_dat = pd;
        rise_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (done !== 1'b1 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check_eq("R9", "done seen", int'(done === 1'b1), 1);
        check_eq("R9", "mdc high at done", int'(mdc), 1);
        @(negedge clk);
        check_eq("R9", "done one cycle", int'(done), 0);
    endtask

    // compare captured slots against the frame the requirements define
    task automatic check_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                               input logic [15:0] wd, input logic flushed);
        int total;
        total = rd ? (flushed ? 79 : 64) : 65;
        check_eq(rd ? (flushed ? "R7" : "R6") : "R8", "slot count", rise_cnt, total);
        for (int n = 0; n < total && n < 128; n++) begin
            logic eoe, ev;
            string rq;
            eoe = 1'b1; ev = 1'b1; rq = "R2";
            if (n >= 32 && n <= 35) begin
                rq = "R3";
                ev = (n == 33) || (n == 34 && rd) || (n == 35 && !rd);
            end else if (n >= 36 && n <= 40) begin
                rq = "R4"; ev = pa[40 - n];
            end else if (n >= 41 && n <= 45) begin
                rq = "R4"; ev = ra[45 - n];
            end else if (n >= 46) begin
                if (rd) begin
                    rq = flushed ? "R7" : "R6"; eoe = 1'b0;
                end else begin
                    rq = "R8";
                    if (n == 46)      ev = 1'b1;
                    else if (n == 47) ev = 1'b0;
                    else if (n <= 63) ev = wd[63 - n];
                    else              eoe = 1'b0;
                end
            end
            check_eq(rq, $sformatf("oe slot %0d", n), int'(cap_oe[n]), int'(eoe));
            if (eoe) check_eq(rq, $sformatf("bit slot %0d", n), int'(cap_v[n]), int'(ev));
        end
    endtask

    task automatic t_reset();
        check_eq("R1", "mdc", int'(mdc), 1);
        check_eq("R1", "oe", int'(mdio_oe), 0);
        check_eq("R1", "done", int'(done), 0);
        check_eq("R1", "err", int'(err), 0);
        check_eq("R1", "rd_data", int'(rd_data), 0);
    endtask

    task automatic t_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
        launch(1'b0, pa, ra, wd, 8'd3, 1'b0, 16'h0);
        wait_done();
        check_frame(1'b0, pa, ra, wd, 1'b0);
        check_eq("R8", "err after write", int'(err), 0);
    endtask

    task automatic t_read(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] pd,
                          input logic [7:0] dv);
        launch(1'b1, pa, ra, 16'h0, dv, 1'b0, pd);
        wait_done();
        check_frame(1'b1, pa, ra, 16'h0, 1'b0);
        check_eq("R6", "rd_data", int'(rd_data), int'(pd));
        check_eq("R6", "err", int'(err), 0);
    endtask

    task automatic t_ta_error();
        launch(1'b1, 5'h03, 5'h02, 16'h0, 8'd2, 1'b1, 16'hBEEF);
        wait_done();
        check_frame(1'b1, 5'h03, 5'h02, 16'h0, 1'b1);
        check_eq("R7", "err", int'(err), 1);
        check_eq("R7", "rd_data", int'(rd_data), 0);
    endtask

    task automatic t_hold(input logic [15:0] exp_d, input logic exp_e);
        repeat (40) @(negedge clk);
        check_eq("R11", "rd_data held", int'(rd_data), int'(exp_d));
        check_eq("R11", "err held", int'(err), int'(exp_e));
        check_eq("R9", "mdc idle high", int'(mdc), 1);
    endtask

    task automatic t_halfper(input logic [7:0] dv, input int exp);
        int hi_n = 0, lo_n = 0;
        launch(1'b0, 5'h0A, 5'h15, 16'h1234, dv, 1'b0, 16'h0);
        @(posedge mdc);
        @(negedge clk);
        while (mdc) begin hi_n++; @(negedge clk); end
        while (!mdc) begin lo_n++; @(negedge clk); end
        check_eq("R5", "high phase clocks", hi_n, exp);
        check_eq("R5", "low phase clocks", lo_n, exp);
        wait_done();
    endtask

    task automatic t_busy();
        int d0;
        d0 = done_cnt;
        launch(1'b0, 5'h11, 5'h0C, 16'h5AF0, 8'd2, 1'b0, 16'h0);
        repeat (100) @(negedge clk);
        rd_nwr = 1'b1; phy_addr = 5'h1E; reg_addr = 5'h01; wr_data = 16'hFFFF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_frame(1'b0, 5'h11, 5'h0C, 16'h5AF0, 1'b0);
        repeat (200) @(negedge clk);
        check_eq("R10", "done pulses for one frame", done_cnt - d0, 1);
        check_eq("R10", "no extra slots", rise_cnt, 65);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write(5'h01, 5'h1F, 16'hA5C3);
        t_read(5'h1A, 5'h05, 16'h8E71, 8'd2);
        t_hold(16'h8E71, 1'b0);
        t_ta_error();
        t_hold(16'h0000, 1'b1);
        t_read(5'h10, 5'h00, 16'h0001, 8'd1);
        t_hold(16'h0001, 1'b0);
        t_read(5'h1F, 5'h1F, 16'hFFFF, 8'd0);
        t_halfper(8'd0, 1);
        t_halfper(8'd5, 5);
        t_busy();
        check_eq("R5", "mdio changes while mdc high", viol, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule